// File: doc/BRIEF.md
# Tear-Free Converter Result Holding Register

This block stores the most recent 10-bit conversion result and lets a processor fetch it as two bytes: a low byte at address 0 and a high byte at address 1. An input bit selects the layout of the result across the 16 bits. When it is clear, the result is right-adjusted. When it is set, the result is left-adjusted, so software that needs only 8 bits of precision can read the high byte alone.

A read of the low byte freezes the register, so that the following high-byte read returns bits from the same result. Results that finish while the register is frozen go into a one-deep pending slot, and a newer result replaces an older one there. A read of the high byte releases the freeze and commits the newest result into the register. Read data is combinational from the address, so it is valid in the same cycle as the strobe.

Control is a three-state machine:
- **OPEN**: the register tracks results.
- **FROZEN**: a low byte has been read and nothing is pending.
- **FROZEN_PEND**: a low byte has been read and a result is waiting.

The transitions are:
- **freeze**: OPEN goes to FROZEN on a low read.
- **freeze_catch**: OPEN goes to FROZEN_PEND on a low read in the same cycle as a new result.
- **park**: FROZEN goes to FROZEN_PEND on a new result.
- **repark**: FROZEN_PEND stays in FROZEN_PEND on a new result, which overwrites the pending slot.
- **release**: FROZEN or FROZEN_PEND goes to OPEN on a high read, and any waiting or simultaneous result is committed.

Top module: `adc_result_hold`

## Requirements
- R1: After reset, both bytes read 0 in either layout and the register is not frozen.
- R2: While not frozen, a result presented with `res_valid` (and no low read in that cycle) is visible at the read port from the next cycle on.
- R3: A low read (`rd_addr`=0 with `rd_en`) freezes the register. Results arriving in that cycle or later do not change the read data until a high read.
- R4: A high read (`rd_addr`=1 with `rd_en`) while frozen unfreezes the register. From the next cycle, the register holds the newest result that arrived during the freeze, including one arriving in the same cycle as the high read. If no result arrived, the register is unchanged.
- R5: With `left_adj`=0, the low byte reads result bits 7:0 and the high byte reads {6'b0, result bits 9:8}.
- R6: With `left_adj`=1, the high byte reads result bits 9:2 and the low byte reads {result bits 1:0, 6'b0}.
- R7: A high read while not frozen only returns data. A result arriving later is still captured as in R2, so reading only the high bytes leaves no freeze behind.
- R8: A change of `left_adj` changes the read data in the same cycle, without any new result.
- R9: A low read returns the result held before any result arriving in the same cycle. That new result is held pending as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | New conversion result present this cycle |
| res_data | input | 10 | Conversion result |
| left_adj | input | 1 | 1 = left-adjusted layout, 0 = right-adjusted |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0 = low byte, 1 = high byte |
| rd_data | output | 8 | Byte selected by rd_addr in the current layout |

## Verification
The hardest situation to reach is a result that arrives in the same cycle as the read that changes the freeze. This covers two cases:
- A result that coincides with the low read must be parked, not shown.
- A result that coincides with the high read must beat an already pending one.

Directed sequences place results on exactly those cycles and also overwrite a pending result several times. A long random phase then mixes strobes, addresses, results and layout flips densely, so these coincidences recur many times.

// File: rtl/adc_hold_pkg.sv
package adc_hold_pkg;
    typedef enum logic [1:0] {
        ST_OPEN        = 2'd0,
        ST_FROZEN      = 2'd1,
        ST_FROZEN_PEND = 2'd2
    } hold_state_t;

    localparam logic ADDR_LO = 1'b0;
    localparam logic ADDR_HI = 1'b1;
endpackage

// File: rtl/adc_lock_fsm.sv
module adc_lock_fsm
    import adc_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lo_rd,
    input  logic        hi_rd,
    input  logic        res_valid,
    output hold_state_t state,
    output logic        load_main,
    output logic        main_from_pend,
    output logic        load_pend
);
    hold_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d        = state_q;
        load_main      = 1'b0;
        main_from_pend = 1'b0;
        load_pend      = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                if (lo_rd) begin
                    // freeze / freeze_catch
                    load_pend = res_valid;
                    state_d   = res_valid ? ST_FROZEN_PEND : ST_FROZEN;
                end else begin
                    load_main = res_valid;
                end
            end
            ST_FROZEN: begin
                if (hi_rd) begin
                    // release
                    load_main = res_valid;
                    state_d   = ST_OPEN;
                end else if (res_valid) begin
                    // park
                    load_pend = 1'b1;
                    state_d   = ST_FROZEN_PEND;
                end
            end
            ST_FROZEN_PEND: begin
                if (hi_rd) begin
                    // release with commit
                    load_main      = 1'b1;
                    main_from_pend = !res_valid;
                    state_d        = ST_OPEN;
                end else begin
                    // repark
                    load_pend = res_valid;
                end
            end
            default: state_d = ST_OPEN;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_main,
    input  logic             main_from_pend,
    input  logic             load_pend,
    input  logic [RES_W-1:0] res_data,
    output logic [RES_W-1:0] main_q
);
    logic [RES_W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
            pend_q <= '0;
        end else begin
            if (load_main) main_q <= main_from_pend ? pend_q : res_data;
            if (load_pend) pend_q <= res_data;
        end
    end
endmodule

// File: rtl/adc_res_format.sv
module adc_res_format #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  value,
    input  logic              left_adj,
    input  logic              sel_hi,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int FULL_W = 2 * BYTE_W;
    localparam int PAD_W  = FULL_W - RES_W;

    logic [FULL_W-1:0] full;

    always_comb begin
        if (left_adj) full = {value, {PAD_W{1'b0}}};
        else          full = {{PAD_W{1'b0}}, value};
        byte_out = sel_hi ? full[FULL_W-1:BYTE_W] : full[BYTE_W-1:0];
    end
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
    import adc_hold_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic              left_adj,
    input  logic              rd_en,
    input  logic              rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    hold_state_t      state_q;
    logic [RES_W-1:0] stored_q;
    logic             load_main, main_from_pend, load_pend;
    logic             lo_rd, hi_rd;

    assign lo_rd = rd_en && (rd_addr == ADDR_LO);
    assign hi_rd = rd_en && (rd_addr == ADDR_HI);

    adc_lock_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .lo_rd          (lo_rd),
        .hi_rd          (hi_rd),
        .res_valid      (res_valid),
        .state          (state_q),
        .load_main      (load_main),
        .main_from_pend (main_from_pend),
        .load_pend      (load_pend)
    );

    adc_res_store #(.RES_W(RES_W)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_main      (load_main),
        .main_from_pend (main_from_pend),
        .load_pend      (load_pend),
        .res_data       (res_data),
        .main_q         (stored_q)
    );

    adc_res_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
        .value    (stored_q),
        .left_adj (left_adj),
        .sel_hi   (rd_addr == ADDR_HI),
        .byte_out (rd_data)
    );
endmodule

// File: rtl/adc_result_hold_chk.sv
module adc_result_hold_chk
    import adc_hold_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [RES_W-1:0]  res_data,
    input logic              left_adj,
    input logic              rd_en,
    input logic              rd_addr,
    input logic [BYTE_W-1:0] rd_data,
    input hold_state_t       state,
    input logic [RES_W-1:0]  stored
);
    localparam int HI_ZERO_LSB = RES_W - BYTE_W;
    localparam int LO_ZERO_MSB = 2 * BYTE_W - RES_W - 1;

    logic c_lo, c_hi;
    assign c_lo = rd_en && !rd_addr;
    assign c_hi = rd_en && rd_addr;

    assert_open_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && !c_lo && res_valid) |=> stored == $past(res_data));

    assert_frozen_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OPEN && !c_hi) |=> $stable(stored));

    assert_low_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_lo |=> state != ST_OPEN);

    assert_high_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        c_hi |=> state == ST_OPEN);

    assert_right_high_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!left_adj && rd_addr) |-> rd_data[BYTE_W-1:HI_ZERO_LSB] == '0);

    assert_left_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (left_adj && !rd_addr) |-> rd_data[LO_ZERO_MSB:0] == '0);

    assert_catch_parks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && c_lo && res_valid) |=> state == ST_FROZEN_PEND && $stable(stored));
endmodule

bind adc_result_hold adc_result_hold_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_data  (res_data),
    .left_adj  (left_adj),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .state     (state_q),
    .stored    (stored_q)
);

// File: tb/adc_result_hold_bench.sv
module adc_result_hold_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_valid = 1'b0;
    logic [9:0] res_data = '0;
    logic       left_adj = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [9:0] m_stored = '0;
    logic [9:0] m_pend = '0;
    logic       m_pv = 1'b0;
    logic       m_locked = 1'b0;

    always #10 clk = ~clk;

    adc_result_hold u_adc_result_hold (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .left_adj(left_adj), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] fmt(logic [9:0] v, logic hi, logic ladj);
        logic [15:0] f;
        f = ladj ? {v, 6'b0} : {6'b0, v};
        return hi ? f[15:8] : f[7:0];
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(string req, logic rv, logic [9:0] rd, logic re, logic ra, logic chk);
        @(negedge clk);
        res_valid = rv; res_data = rd; rd_en = re; rd_addr = ra;
        #2;
        if (chk) check(req, rd_data, fmt(m_stored, ra, left_adj));
        @(posedge clk);
        if (!m_locked) begin
            if (re && !ra) begin
                m_locked = 1'b1;
                if (rv) begin m_pend = rd; m_pv = 1'b1; end
            end else if (rv) m_stored = rd;
        end else begin
            if (re && ra) begin
                if (rv) m_stored = rd;
                else if (m_pv) m_stored = m_pend;
                m_pv = 1'b0; m_locked = 1'b0;
            end else if (rv) begin
                m_pend = rd; m_pv = 1'b1;
            end
        end
    endtask

    task automatic peek(string req, logic ra);
        step(req, 1'b0, '0, 1'b0, ra, 1'b1);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2468));
        #35 rst_n = 1'b1;
        // R1 reset state, both layouts
        peek("R1", 1'b0); peek("R1", 1'b1);
        left_adj = 1'b1;
        peek("R1", 1'b0); peek("R1", 1'b1);
        left_adj = 1'b0;
        // R2 capture while open
        step("R2", 1'b1, 10'h2A5, 1'b0, 1'b0, 1'b0);
        peek("R2", 1'b0); peek("R5", 1'b1);
        check("R5", rd_data, 8'h02);
        // R8 layout flip without new result
        left_adj = 1'b1; #1;
        check("R8", rd_data, 8'hA9);
        peek("R6", 1'b0);
        left_adj = 1'b0;
        // R9 + R3: low read with simultaneous result
        step("R9", 1'b1, 10'h155, 1'b1, 1'b0, 1'b1);
        step("R3", 1'b1, 10'h0F0, 1'b0, 1'b0, 1'b0);
        peek("R3", 1'b0); peek("R3", 1'b1);
        // R4 release commits newest pending
        step("R4", 1'b0, '0, 1'b1, 1'b1, 1'b1);
        peek("R4", 1'b0);
        check("R4", rd_data, 8'hF0);
        // R4 release with simultaneous result beating pending
        step("R3", 1'b0, '0, 1'b1, 1'b0, 1'b1);
        step("R3", 1'b1, 10'h111, 1'b0, 1'b0, 1'b0);
        step("R4", 1'b1, 10'h3C3, 1'b1, 1'b1, 1'b1);
        peek("R4", 1'b0); peek("R4", 1'b1);
        check("R4", rd_data, 8'h03);
        // R4 release with nothing pending: unchanged
        step("R3", 1'b0, '0, 1'b1, 1'b0, 1'b1);
        step("R4", 1'b0, '0, 1'b1, 1'b1, 1'b1);
        peek("R4", 1'b0);
        // R7 high-only reads in left layout leave no freeze
        left_adj = 1'b1;
        step("R7", 1'b0, '0, 1'b1, 1'b1, 1'b1);
        step("R7", 1'b0, '0, 1'b1, 1'b1, 1'b1);
        step("R7", 1'b1, 10'h2F1, 1'b0, 1'b0, 1'b0);
        peek("R7", 1'b1);
        check("R7", rd_data, 8'hBC);
        peek("R6", 1'b0);
        check("R6", rd_data, 8'h40);
        left_adj = 1'b0;
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic rv, re, ra;
            if ($urandom_range(0, 15) == 0) left_adj = ~left_adj;
            rv = ($urandom_range(0, 9) < 4);
            re = ($urandom_range(0, 9) < 5);
            ra = $urandom_range(0, 1);
            step(m_locked ? "R3" : (left_adj ? "R6" : "R5"),
                 rv, 10'($urandom_range(0, 1023)), re, ra, 1'b1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule